// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block keeps the active divider settings of a clock synthesizer: a 9-bit feedback divide count, a 2-bit output divide select and a 2-bit test-pin select. Software or board straps write these settings in one of two ways. The first way is a parallel port with an active-low strobe. The second way is a three-wire serial port with data, clock and load lines.

All strobe, clock and data pins are asynchronous to the block. Each one passes through a two-flop synchronizer into the system clock domain. Edges are detected after the synchronizer, so each pin edge produces exactly one update.

A multiplexer drives the test pin. It selects one of four sources: a constant low, the serial shift path, the feedback divider output or the synthesized output clock. The block also flags feedback counts that would keep the loop from locking with a 25 MHz reference.

Top module: `synth_cfg_loader`

## Requirements
- R1: After rst_ni is released, the outputs are m_o=20, n_o=0, t_o=0, div_ratio_o=1, m_range_err_o=0 and test_o=0.
- R2: While pload_ni is low (parallel mode), m_o and n_o follow par_m_i and par_n_i a few clocks later. t_o is left unchanged.
- R3: After pload_ni rises, m_o and n_o keep the last values captured while it was low. Changes on par_m_i and par_n_i while pload_ni is high have no effect.
- R4: While pload_ni is high, each rising edge of sclk_i shifts sdata_i into a 14-bit register. A rising edge of sload_i copies that register to the outputs. The first bit sent lands in t_o[1], the second in t_o[0], the third is a spare slot, the next two go to n_o[1:0] (MSB first), and the last nine go to m_o[8:0] (MSB first).
- R5: The value sent in the spare third slot has no effect on any output.
- R6: After sload_i falls, further serial clocks do not change m_o, n_o or t_o.
- R7: While sload_i is held high, every rising sclk_i edge updates m_o, n_o and t_o from the register as it stands just after that shift.
- R8: With t_o equal to 00, test_o is low. With 01, test_o is the oldest bit in the shift register (bit 13). With 10, test_o follows mdiv_fb_i. With 11, test_o follows fout_i.
- R9: test_o is low whenever the block is in parallel mode.
- R10: While mr_i is high, test_o is low, and m_o, n_o and t_o are unchanged.
- R11: div_ratio_o is 1, 2, 4 or 8 for n_o equal to 0, 1, 2 or 3.
- R12: m_range_err_o is high exactly when m_o is below 10 or above 28.
- R13: One rising edge on sclk_i shifts exactly one bit, however long the pin stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mr_i | input | 1 | Master reset: forces test_o low and keeps the settings |
| pload_ni | input | 1 | Parallel strobe; low means transparent |
| par_m_i | input | 9 | Parallel feedback divide count |
| par_n_i | input | 2 | Parallel output divide select |
| sload_i | input | 1 | Serial load line |
| sclk_i | input | 1 | Serial clock line |
| sdata_i | input | 1 | Serial data line |
| mdiv_fb_i | input | 1 | Feedback divider output, a test source |
| fout_i | input | 1 | Synthesized output clock, a test source |
| m_o | output | 9 | Active feedback divide count |
| n_o | output | 2 | Active output divide select |
| t_o | output | 2 | Active test-pin select |
| div_ratio_o | output | 4 | Output divide ratio decoded from n_o |
| m_range_err_o | output | 1 | Feedback count outside 10..28 |
| test_o | output | 1 | Test pin |

## Verification
The bench holds every serial clock and strobe level for several synchronizer periods. If the edge detector fired on a level rather than an edge, a long pin pulse would shift more than one bit and break every frame, so this hold time exposes that fault.

Frames use a set spare-slot bit and boundary counts (9, 10, 28, 29, 0, 511). A design that shifted in the wrong direction or misplaced the spare slot would show the wrong fields in m_o, n_o and t_o. A design with an off-by-one range bound would show the wrong m_range_err_o.

After a serial load, the bench keeps clocking with the load line low, to catch settings that keep following the shifts. It also runs a flow-through pass and checks every step, to catch a design that updates only on the load edge.

It then drives parallel mode and master reset with an active clock source selected. A design that missed either gate would let that clock reach the test pin.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 2;
  localparam int SPARE_W = 1;
  localparam int FRAME_W = T_W + SPARE_W + N_W + M_W;
  localparam int RATIO_W = 1 << N_W;
  localparam int N_LSB   = M_W;
  localparam int T_LSB   = M_W + N_W + SPARE_W;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;

  typedef enum logic [T_W-1:0] {
    TSEL_LOW   = 2'b00,
    TSEL_SHIFT = 2'b01,
    TSEL_MFB   = 2'b10,
    TSEL_FOUT  = 2'b11
  } tsel_e;
endpackage

// File: rtl/sync_bits.sv
module sync_bits #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q[0] <= RST_VAL;
    else         st_q[0] <= d_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[k] <= RST_VAL;
      else         st_q[k] <= st_q[k-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  sync_bits #(.W(W), .STAGES(STAGES), .RST_VAL(RST_VAL)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (d_i),
    .q_o   (lvl_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_o;
  end

  for (genvar b = 0; b < W; b++) begin : g_edge
    assign rise_o[b] = lvl_o[b] & ~prev_q[b];

    AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[b] |=> !rise_o[b]); // R13
  end
endmodule

// File: rtl/cfg_shreg.sv
module cfg_shreg #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         din_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] nxt_o
);
  assign nxt_o = {q_o[W-2:0], din_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (shift_i) q_o <= nxt_o;
  end

  AST_SHIFT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(q_o)); // R13
endmodule

// File: rtl/cfg_test_mux.sv
module cfg_test_mux
  import synth_cfg_pkg::*;
(
  input  logic [T_W-1:0] sel_i,
  input  logic           en_i,
  input  logic           shift_i,
  input  logic           mfb_i,
  input  logic           fout_i,
  output logic           test_o
);
  logic raw;

  always_comb begin
    unique case (tsel_e'(sel_i))
      TSEL_LOW:   raw = 1'b0;
      TSEL_SHIFT: raw = shift_i;
      TSEL_MFB:   raw = mfb_i;
      TSEL_FOUT:  raw = fout_i;
      default:    raw = 1'b0;
    endcase
  end

  assign test_o = en_i & raw;
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEF_M       = 20,
  parameter int LOCK_MIN    = 10,
  parameter int LOCK_MAX    = 28
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mr_i,
  input  logic               pload_ni,
  input  logic [M_W-1:0]     par_m_i,
  input  logic [N_W-1:0]     par_n_i,
  input  logic               sload_i,
  input  logic               sclk_i,
  input  logic               sdata_i,
  input  logic               mdiv_fb_i,
  input  logic               fout_i,
  output logic [M_W-1:0]     m_o,
  output logic [N_W-1:0]     n_o,
  output logic [T_W-1:0]     t_o,
  output logic [RATIO_W-1:0] div_ratio_o,
  output logic               m_range_err_o,
  output logic               test_o
);
  localparam logic [M_W-1:0] M_LO  = M_W'(LOCK_MIN);
  localparam logic [M_W-1:0] M_HI  = M_W'(LOCK_MAX);
  localparam logic [M_W-1:0] M_DEF = M_W'(DEF_M);

  // slow-strobe pins: level only; serial control pins: level + rising edge
  logic [1:0] lvl_a;
  logic [1:0] lvl_s, rise_s;

  sync_bits #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync_lvl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pload_ni, sdata_i}),
    .q_o   (lvl_a)
  );

  sync_edge #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_ser (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sload_i, sclk_i}),
    .lvl_o (lvl_s),
    .rise_o(rise_s)
  );

  logic par_mode, sdata_s, sload_s, sload_rise, sclk_rise;
  assign par_mode   = ~lvl_a[1];
  assign sdata_s    = lvl_a[0];
  assign sload_s    = lvl_s[1];
  assign sload_rise = rise_s[1];
  assign sclk_rise  = rise_s[0];

  logic               shift_en;
  logic [FRAME_W-1:0] sr_q, sr_nxt;
  assign shift_en = sclk_rise & ~par_mode;

  cfg_shreg #(.W(FRAME_W)) u_shreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift_en),
    .din_i  (sdata_s),
    .q_o    (sr_q),
    .nxt_o  (sr_nxt)
  );

  cfg_t cfg_q, from_nxt, from_cur;

  assign from_nxt.t = sr_nxt[T_LSB +: T_W];
  assign from_nxt.n = sr_nxt[N_LSB +: N_W];
  assign from_nxt.m = sr_nxt[M_W-1:0];
  assign from_cur.t = sr_q[T_LSB +: T_W];
  assign from_cur.n = sr_q[N_LSB +: N_W];
  assign from_cur.m = sr_q[M_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{t: '0, n: '0, m: M_DEF};
    end else if (par_mode) begin
      cfg_q.m <= par_m_i;
      cfg_q.n <= par_n_i;
    end else if (sclk_rise && sload_s) begin
      cfg_q <= from_nxt;
    end else if (sload_rise) begin
      cfg_q <= from_cur;
    end
  end

  assign m_o           = cfg_q.m;
  assign n_o           = cfg_q.n;
  assign t_o           = cfg_q.t;
  assign div_ratio_o   = RATIO_W'(1) << cfg_q.n;
  assign m_range_err_o = (cfg_q.m < M_LO) || (cfg_q.m > M_HI);

  cfg_test_mux u_tmux (
    .sel_i  (cfg_q.t),
    .en_i   (~par_mode & ~mr_i),
    .shift_i(sr_q[FRAME_W-1]),
    .mfb_i  (mdiv_fb_i),
    .fout_i (fout_i),
    .test_o (test_o)
  );

  AST_PAR_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_mode |=> (m_o == $past(par_m_i)) && (n_o == $past(par_n_i))); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!par_mode && !sclk_rise && !sload_rise) |=> ($stable(m_o) && $stable(n_o) && $stable(t_o))); // R6

  AST_FLOW_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!par_mode && sclk_rise && sload_s) |=> (m_o == sr_q[M_W-1:0])); // R7

  AST_TEST_PAR_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_mode |-> !test_o); // R9

  AST_MR_TEST_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mr_i |-> !test_o); // R10

  AST_T_KEPT_PAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_mode |=> $stable(t_o)); // R2
endmodule

// File: tb/synth_cfg_loader_tb_top.sv
module synth_cfg_loader_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic mr_i = 1'b0, pload_ni = 1'b1, sload_i = 1'b0, sclk_i = 1'b0, sdata_i = 1'b0;
  logic mdiv_fb_i = 1'b1, fout_i = 1'b1;
  logic [8:0] par_m_i = '0;
  logic [1:0] par_n_i = '0;
  logic [8:0] m_o;
  logic [1:0] n_o, t_o;
  logic [3:0] div_ratio_o;
  logic m_range_err_o, test_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [13:0] sr_m = '0;

  always #10 clk_i = ~clk_i;

  synth_cfg_loader dut_i (
    .clk_i, .rst_ni, .mr_i, .pload_ni, .par_m_i, .par_n_i, .sload_i, .sclk_i,
    .sdata_i, .mdiv_fb_i, .fout_i, .m_o, .n_o, .t_o, .div_ratio_o,
    .m_range_err_o, .test_o
  );

  // frame[18:5] = {T1,T0,spare,N1,N0,M8..M0}, [4:1] expected ratio, [0] expected range flag
  localparam logic [18:0] VEC [8] = '{
    {2'b01, 1'b0, 2'b00, 9'd10,  4'd1, 1'b0},
    {2'b10, 1'b1, 2'b01, 9'd28,  4'd2, 1'b0},
    {2'b11, 1'b0, 2'b10, 9'd9,   4'd4, 1'b1},
    {2'b00, 1'b1, 2'b11, 9'd29,  4'd8, 1'b1},
    {2'b01, 1'b0, 2'b01, 9'd511, 4'd2, 1'b1},
    {2'b10, 1'b1, 2'b10, 9'd0,   4'd4, 1'b1},
    {2'b00, 1'b0, 2'b00, 9'd20,  4'd1, 1'b0},
    {2'b11, 1'b1, 2'b11, 9'd17,  4'd8, 1'b0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic send_bit(input logic b);
    sdata_i = b;  settle();
    sclk_i = 1'b1; settle();   // held several cycles: must still shift once (R13)
    sclk_i = 1'b0; settle();
    sr_m = {sr_m[12:0], b};
  endtask

  task automatic send_frame(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic pulse_load();
    sload_i = 1'b1; settle();
    sload_i = 1'b0; settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-reqs actual=hang expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    settle();
    chk("R1", "m_o", m_o, 20);
    chk("R1", "n_o", n_o, 0);
    chk("R1", "t_o", t_o, 0);
    chk("R1", "ratio", div_ratio_o, 1);
    chk("R1", "err", m_range_err_o, 0);
    chk("R1", "test_o", test_o, 0);

    // parallel transparent, then latch
    pload_ni = 1'b0; par_m_i = 9'd25; par_n_i = 2'd2; settle();
    chk("R2", "m_o", m_o, 25);
    chk("R2", "n_o", n_o, 2);
    chk("R11", "ratio n=2", div_ratio_o, 4);
    par_m_i = 9'd12; par_n_i = 2'd1; settle();
    chk("R2", "m_o follows", m_o, 12);
    chk("R2", "t_o kept", t_o, 0);
    pload_ni = 1'b1; settle();
    par_m_i = 9'd300; par_n_i = 2'd3; settle();
    chk("R3", "m_o held", m_o, 12);
    chk("R3", "n_o held", n_o, 1);

    // serial vector table
    for (int v = 0; v < 8; v++) begin
      logic [13:0] f;
      f = VEC[v][18:5];
      send_frame(f);
      pulse_load();
      chk("R4", "m_o", m_o, f[8:0]);
      chk("R4", "n_o", n_o, f[10:9]);
      chk("R4", "t_o", t_o, f[13:12]);
      chk("R11", "ratio", div_ratio_o, VEC[v][4:1]);
      chk("R12", "err", m_range_err_o, VEC[v][0]);
      chk("R8", "test_o", test_o, (f[13:12] == 2'b00) ? 0 : (f[13:12] == 2'b01) ? f[13] : 1);
      if (f[11]) chk("R5", "spare ignored m_o", m_o, f[8:0]);
    end

    // R6: extra shifts after load leave settings alone
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    chk("R6", "m_o", m_o, 17);
    chk("R6", "t_o", t_o, 3);

    // R8: shift path visible on test pin
    send_frame({2'b01, 1'b0, 2'b00, 9'd15});
    pulse_load();
    chk("R8", "test sel01 bit13=0", test_o, 0);
    send_bit(1'b0);
    chk("R8", "test sel01 bit13=1", test_o, 1);
    chk("R6", "m_o after shift", m_o, 15);
    send_frame({2'b10, 1'b0, 2'b00, 9'd15});
    pulse_load();
    mdiv_fb_i = 1'b0; #1;
    chk("R8", "sel10 mfb=0", test_o, 0);
    fout_i = 1'b0; mdiv_fb_i = 1'b1; #1;
    chk("R8", "sel10 mfb=1", test_o, 1);
    send_frame({2'b11, 1'b0, 2'b00, 9'd15});
    pulse_load();
    chk("R8", "sel11 fout=0", test_o, 0);
    fout_i = 1'b1; #1;
    chk("R8", "sel11 fout=1", test_o, 1);

    // R10: master reset
    mr_i = 1'b1; settle();
    chk("R10", "test_o low", test_o, 0);
    chk("R10", "m_o kept", m_o, 15);
    chk("R10", "t_o kept", t_o, 3);
    mr_i = 1'b0; #1;
    chk("R10", "test_o back", test_o, 1);

    // R9: parallel mode forces test low
    par_m_i = 9'd22; par_n_i = 2'd0;
    pload_ni = 1'b0; settle();
    chk("R9", "test_o", test_o, 0);
    chk("R2", "m_o", m_o, 22);
    chk("R2", "t_o kept", t_o, 3);
    pload_ni = 1'b1; settle();
    chk("R9", "test_o serial again", test_o, 1);

    // R7: flow-through with load held high
    sload_i = 1'b1; settle();
    begin
      logic [13:0] ff;
      ff = {2'b01, 1'b1, 2'b10, 9'd300};
      for (int i = 13; i >= 0; i--) begin
        send_bit(ff[i]);
        chk("R7", "m_o step", m_o, sr_m[8:0]);
      end
      chk("R7", "n_o", n_o, 2);
      chk("R7", "t_o", t_o, 1);
      chk("R12", "err m=300", m_range_err_o, 1);
    end
    sload_i = 1'b0; settle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule